// File: doc/BRIEF.md
# Prioritizing Vectored Interrupt Controller

This block samples a vector of level-sensitive interrupt request lines from peripherals. It picks the single most urgent enabled request and presents it to a processor core as a full request tuple. The tuple holds the address of the service routine, a 6-bit interrupt level, the index of the register bank the routine should run in, and a flag that marks the request as nonmaskable. Software sets each source's enable, level, nonmaskable flag, bank index and service address through a small register write/read port.

Controllers can be chained. An upstream controller offers its own best tuple on the chain input, and this block merges that tuple with its local winner. The controller closest to the processor therefore presents the most urgent request of the whole chain. Several low-criticality sources may share one bank index, and a critical source may be given a bank of its own. The selected tuple is registered, so the outputs move only on clock edges.

Top module: `irq_vector_ctrl`

## Requirements
- R1: There are 32 active-high, level-sensitive request inputs. A source takes part in selection only while its enable bit is 1, so a disabled source is never presented.
- R2: Configuration address = {source index, select bit}. Select 0 is the control word: bit 0 enable, bit 1 nonmaskable flag, bits 7:2 level, bits 11:8 bank index. Select 1 is the 32-bit service address. The read port returns the stored values combinationally from the address, and unused control bits read 0.
- R3: A request flagged nonmaskable always wins over any maskable request.
- R4: Requests of the same class are ranked by level, and the higher level wins. On equal class and level, the lower source index wins.
- R5: The presented tuple is the winning source's service address, level, bank index and nonmaskable flag. Sources may share a bank index.
- R6: The chain input wins only when its {nonmaskable, level} key is strictly greater than the local winner's key; on equal keys the local request wins. With no local request, a valid chain tuple is passed through unchanged.
- R7: The valid output rises one clock after a qualifying request appears. It falls one clock after no enabled source is active and the chain input is idle.
- R8: While the valid output is low, the tuple outputs keep their last presented value.
- R9: Synchronous reset clears every source to disabled, level 0, maskable, bank 0 and address 0. It also clears the valid output and the tuple outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 32 | Peripheral request lines |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 6 | {source index, select} |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read data for cfgAddr |
| upValid | input | 1 | Chain tuple valid |
| upHandler | input | 32 | Chain service address |
| upLevel | input | 6 | Chain level |
| upRegSet | input | 4 | Chain bank index |
| upNmi | input | 1 | Chain nonmaskable flag |
| reqValid | output | 1 | Presented tuple valid |
| reqHandler | output | 32 | Presented service address |
| reqLevel | output | 6 | Presented level |
| reqRegSet | output | 4 | Presented bank index |
| reqNmi | output | 1 | Presented nonmaskable flag |

## Verification
A sweep with one source active at a time shows that each source's own tuple is routed to the outputs. A sweep over many pairs of sources separates ranking by level from tie-breaking by index, because levels repeat every eight sources. The all-active patterns are repeated after disabling the top source and after flagging a low-level source as nonmaskable. These show that the enable gate and the nonmaskable class override level. Chain tuples with a lower, equal and higher key than the local winner test the strict-greater merge rule, and idle steps between patterns test the valid fall and the hold of the tuple.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // Strobes issued by the control path to the datapath
  typedef struct packed {
    logic wrCtl;    // write the control word of the addressed source
    logic wrHnd;    // write the service address of the addressed source
    logic loadOut;  // capture the selected tuple into the output stage
  } vicStrobe_t;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_NMI_BIT = 1;
  localparam int CTL_LVL_LSB = 2;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int SRC_W = 5
) (
  input  logic             cfgWrEn,
  input  logic [SRC_W:0]   cfgAddr,
  input  logic             candValid,
  output vicStrobe_t       strb,
  output logic [SRC_W-1:0] wrIdx
);
  always_comb begin
    wrIdx        = cfgAddr[SRC_W:1];
    strb.wrCtl   = cfgWrEn && !cfgAddr[0];
    strb.wrHnd   = cfgWrEn && cfgAddr[0];
    strb.loadOut = candValid;
  end
endmodule

// File: rtl/vic_cfg.sv
module vic_cfg
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int SRC_W   = 5,
  parameter int HND_W   = 32,
  parameter int LVL_W   = 6,
  parameter int RS_W    = 4,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  vicStrobe_t        strb,
  input  logic [SRC_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SRC_W-1:0]  rdIdx,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_SRC-1:0] srcEn,
  output logic [NUM_SRC-1:0] srcNmi,
  output logic [LVL_W-1:0]  srcLvl [NUM_SRC],
  output logic [RS_W-1:0]   srcRs  [NUM_SRC],
  output logic [HND_W-1:0]  srcHnd [NUM_SRC]
);
  localparam int RS_LSB = CTL_LVL_LSB + LVL_W;
  localparam int CTL_W  = RS_LSB + RS_W;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    always_ff @(posedge clk) begin
      if (rst) begin
        srcEn[g]  <= 1'b0;
        srcNmi[g] <= 1'b0;
        srcLvl[g] <= '0;
        srcRs[g]  <= '0;
        srcHnd[g] <= '0;
      end else if (strb.wrCtl && wrIdx == SRC_W'(g)) begin
        srcEn[g]  <= wrData[CTL_EN_BIT];
        srcNmi[g] <= wrData[CTL_NMI_BIT];
        srcLvl[g] <= wrData[CTL_LVL_LSB +: LVL_W];
        srcRs[g]  <= wrData[RS_LSB +: RS_W];
      end else if (strb.wrHnd && wrIdx == SRC_W'(g)) begin
        srcHnd[g] <= wrData[HND_W-1:0];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdSel) rdData[HND_W-1:0] = srcHnd[rdIdx];
    else       rdData[CTL_W-1:0] = {srcRs[rdIdx], srcLvl[rdIdx], srcNmi[rdIdx], srcEn[rdIdx]};
  end

  // R2
  ctl_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    strb.wrCtl |=> srcEn[$past(wrIdx)] == $past(wrData[CTL_EN_BIT]));
endmodule

// File: rtl/vic_select.sv
module vic_select
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int SRC_W   = 5,
  parameter int HND_W   = 32,
  parameter int LVL_W   = 6,
  parameter int RS_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  vicStrobe_t         strb,
  input  logic [NUM_SRC-1:0] irq,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] srcNmi,
  input  logic [LVL_W-1:0]   srcLvl [NUM_SRC],
  input  logic [RS_W-1:0]    srcRs  [NUM_SRC],
  input  logic [HND_W-1:0]   srcHnd [NUM_SRC],
  input  logic               upValid,
  input  logic [HND_W-1:0]   upHandler,
  input  logic [LVL_W-1:0]   upLevel,
  input  logic [RS_W-1:0]    upRegSet,
  input  logic               upNmi,
  output logic               candValid,
  output logic               reqValid,
  output logic [HND_W-1:0]   reqHandler,
  output logic [LVL_W-1:0]   reqLevel,
  output logic [RS_W-1:0]    reqRegSet,
  output logic               reqNmi
);
  localparam int KEY_W = LVL_W + 1;

  logic [NUM_SRC-1:0] liveVec;
  logic               locHit;
  logic [KEY_W-1:0]   locKey;
  logic [SRC_W-1:0]   locIdx;
  logic               upWins;
  logic [HND_W-1:0]   candHnd;
  logic [LVL_W-1:0]   candLvl;
  logic [RS_W-1:0]    candRs;
  logic               candNmi;

  assign liveVec = irq & srcEn;

  // Linear scan: strict compare keeps the lowest index on ties
  always_comb begin
    locHit = 1'b0;
    locKey = '0;
    locIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (liveVec[i] && (!locHit || {srcNmi[i], srcLvl[i]} > locKey)) begin
        locHit = 1'b1;
        locKey = {srcNmi[i], srcLvl[i]};
        locIdx = SRC_W'(i);
      end
    end
  end

  always_comb begin
    upWins    = upValid && (!locHit || {upNmi, upLevel} > locKey);
    candValid = locHit || upValid;
    if (upWins) begin
      candHnd = upHandler;
      candLvl = upLevel;
      candRs  = upRegSet;
      candNmi = upNmi;
    end else begin
      candHnd = srcHnd[locIdx];
      candLvl = srcLvl[locIdx];
      candRs  = srcRs[locIdx];
      candNmi = srcNmi[locIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reqValid   <= 1'b0;
      reqHandler <= '0;
      reqLevel   <= '0;
      reqRegSet  <= '0;
      reqNmi     <= 1'b0;
    end else begin
      reqValid <= strb.loadOut;
      if (strb.loadOut) begin
        reqHandler <= candHnd;
        reqLevel   <= candLvl;
        reqRegSet  <= candRs;
        reqNmi     <= candNmi;
      end
    end
  end

  // R6
  chain_taken_chk: assert property (@(posedge clk) disable iff (rst)
    upValid |=> reqValid);
  // R3
  nmi_outranks_chk: assert property (@(posedge clk) disable iff (rst)
    (upValid && upNmi) |=> reqNmi);
  // R6
  chain_level_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (upValid && !upNmi) |=> (reqNmi || reqLevel >= $past(upLevel)));
  // R7
  idle_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (!upValid && liveVec == '0) |=> !reqValid);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reqValid |-> ($stable(reqHandler) && $stable(reqLevel) && $stable(reqRegSet) && $stable(reqNmi)));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int HND_W   = 32,
  parameter int LVL_W   = 6,
  parameter int RS_W    = 4,
  parameter int DATA_W  = 32,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq,
  input  logic               cfgWrEn,
  input  logic [SRC_W:0]     cfgAddr,
  input  logic [DATA_W-1:0]  cfgWrData,
  output logic [DATA_W-1:0]  cfgRdData,
  input  logic               upValid,
  input  logic [HND_W-1:0]   upHandler,
  input  logic [LVL_W-1:0]   upLevel,
  input  logic [RS_W-1:0]    upRegSet,
  input  logic               upNmi,
  output logic               reqValid,
  output logic [HND_W-1:0]   reqHandler,
  output logic [LVL_W-1:0]   reqLevel,
  output logic [RS_W-1:0]    reqRegSet,
  output logic               reqNmi
);
  vicStrobe_t         strb;
  logic [SRC_W-1:0]   wrIdx;
  logic               candValid;
  logic [NUM_SRC-1:0] srcEn;
  logic [NUM_SRC-1:0] srcNmi;
  logic [LVL_W-1:0]   srcLvl [NUM_SRC];
  logic [RS_W-1:0]    srcRs  [NUM_SRC];
  logic [HND_W-1:0]   srcHnd [NUM_SRC];

  vic_ctrl #(.SRC_W(SRC_W)) u_ctrl (
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .candValid(candValid),
    .strb(strb), .wrIdx(wrIdx)
  );

  vic_cfg #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .HND_W(HND_W), .LVL_W(LVL_W),
            .RS_W(RS_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .strb(strb), .wrIdx(wrIdx), .wrData(cfgWrData),
    .rdIdx(cfgAddr[SRC_W:1]), .rdSel(cfgAddr[0]), .rdData(cfgRdData),
    .srcEn(srcEn), .srcNmi(srcNmi), .srcLvl(srcLvl), .srcRs(srcRs), .srcHnd(srcHnd)
  );

  vic_select #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .HND_W(HND_W), .LVL_W(LVL_W),
               .RS_W(RS_W)) u_sel (
    .clk(clk), .rst(rst), .strb(strb), .irq(irq),
    .srcEn(srcEn), .srcNmi(srcNmi), .srcLvl(srcLvl), .srcRs(srcRs), .srcHnd(srcHnd),
    .upValid(upValid), .upHandler(upHandler), .upLevel(upLevel),
    .upRegSet(upRegSet), .upNmi(upNmi), .candValid(candValid),
    .reqValid(reqValid), .reqHandler(reqHandler), .reqLevel(reqLevel),
    .reqRegSet(reqRegSet), .reqNmi(reqNmi)
  );

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    $past(rst) && rst |-> (!reqValid && reqLevel == '0 && !reqNmi));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq = '0;
  logic        cfgWrEn = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        upValid = 1'b0;
  logic [31:0] upHandler = '0;
  logic [5:0]  upLevel = '0;
  logic [3:0]  upRegSet = '0;
  logic        upNmi = 1'b0;
  logic        reqValid;
  logic [31:0] reqHandler;
  logic [5:0]  reqLevel;
  logic [3:0]  reqRegSet;
  logic        reqNmi;

  int checks = 0;
  int failures = 0;

  bit          mEn [32];
  bit          mNmi[32];
  int          mLvl[32];
  int          mRs [32];
  logic [31:0] mHnd[32];

  logic [31:0] heldH = '0;
  logic [5:0]  heldL = '0;
  logic [3:0]  heldR = '0;
  logic        heldN = 1'b0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst(rst), .irq(irq), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .upValid(upValid),
    .upHandler(upHandler), .upLevel(upLevel), .upRegSet(upRegSet), .upNmi(upNmi),
    .reqValid(reqValid), .reqHandler(reqHandler), .reqLevel(reqLevel),
    .reqRegSet(reqRegSet), .reqNmi(reqNmi)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input int src, input bit sel, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgAddr = {src[4:0], sel};
    cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  function automatic logic [31:0] ctlWord(input int i);
    return {20'd0, mRs[i][3:0], mLvl[i][5:0], mNmi[i], mEn[i]};
  endfunction

  task automatic setSrc(input int i, input bit en, input bit nmi, input int lvl, input int rs, input logic [31:0] hnd);
    mEn[i] = en; mNmi[i] = nmi; mLvl[i] = lvl; mRs[i] = rs; mHnd[i] = hnd;
    cfgWrite(i, 1'b0, ctlWord(i));
    cfgWrite(i, 1'b1, hnd);
  endtask

  task automatic step(input logic [31:0] v, input logic uv, input logic [31:0] uh,
                      input logic [5:0] ul, input logic [3:0] ur, input logic un, input string tag);
    int best;
    int bk;
    int k;
    logic ev;
    logic [31:0] eh;
    logic [5:0] el;
    logic [3:0] er;
    logic en;
    best = -1; bk = -1;
    for (int i = 0; i < 32; i++) begin
      if (v[i] && mEn[i]) begin
        k = (mNmi[i] ? 64 : 0) + mLvl[i];
        if (k > bk) begin bk = k; best = i; end
      end
    end
    ev = (best >= 0) || uv;
    eh = heldH; el = heldL; er = heldR; en = heldN;
    if (uv && ((un ? 64 : 0) + int'(ul)) > bk) begin
      eh = uh; el = ul; er = ur; en = un;
    end else if (best >= 0) begin
      eh = mHnd[best]; el = mLvl[best][5:0]; er = mRs[best][3:0]; en = mNmi[best];
    end
    @(negedge clk);
    irq = v; upValid = uv; upHandler = uh; upLevel = ul; upRegSet = ur; upNmi = un;
    @(negedge clk);
    check({tag, " valid"}, {31'd0, reqValid}, {31'd0, ev});
    check({tag, " handler"}, reqHandler, eh);
    check({tag, " level"}, {26'd0, reqLevel}, {26'd0, el});
    check({tag, " regset"}, {28'd0, reqRegSet}, {28'd0, er});
    check({tag, " nmi"}, {31'd0, reqNmi}, {31'd0, en});
    heldH = eh; heldL = el; heldR = er; heldN = en;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      mEn[i] = 0; mNmi[i] = 0; mLvl[i] = 0; mRs[i] = 0; mHnd[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9: reset state of outputs and every configuration word
    check("R9 valid after reset", {31'd0, reqValid}, 32'd0);
    check("R9 handler after reset", reqHandler, 32'd0);
    for (int a = 0; a < 64; a++) begin
      cfgAddr = a[5:0];
      #0.1;
      check("R9 config after reset", cfgRdData, 32'd0);
    end

    // R2 / R5: program all sources; levels repeat every 8, banks shared
    for (int i = 0; i < 32; i++)
      setSrc(i, 1'b1, 1'b0, (i % 8) * 7, i % 4, 32'h8000_0000 + 32'(i) * 32'h40);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      cfgAddr = {i[4:0], 1'b0};
      #0.1;
      check("R2 ctl readback", cfgRdData, ctlWord(i));
      cfgAddr = {i[4:0], 1'b1};
      #0.1;
      check("R2 handler readback", cfgRdData, mHnd[i]);
    end

    // R5 / R7 / R8: each source alone, followed by an idle step
    for (int i = 0; i < 32; i++) begin
      step(32'd1 << i, 1'b0, '0, '0, '0, 1'b0, "R5 single source");
      step('0, 1'b0, '0, '0, '0, 1'b0, "R7 R8 idle hold");
    end

    // R4: pairs ranked by level, ties to lower index
    for (int i = 0; i < 32; i += 3)
      for (int j = 0; j < 32; j += 5)
        if (i != j) step((32'd1 << i) | (32'd1 << j), 1'b0, '0, '0, '0, 1'b0, "R4 pair");
    step('1, 1'b0, '0, '0, '0, 1'b0, "R4 all active tie");

    // R1: disabled sources are never presented
    setSrc(7, 1'b0, 1'b0, 49, 3, mHnd[7]);
    step('1, 1'b0, '0, '0, '0, 1'b0, "R1 disabled top");
    step(32'h0000_0080, 1'b0, '0, '0, '0, 1'b0, "R1 only disabled active");

    // R3: a level-0 nonmaskable source beats all maskable ones
    setSrc(30, 1'b1, 1'b1, 0, 9, 32'hA000_0000);
    step('1, 1'b0, '0, '0, '0, 1'b0, "R3 nmi wins");
    step(32'h0000_8000, 1'b0, '0, '0, '0, 1'b0, "R3 maskable alone");

    // R6: chain merging
    step('0, 1'b1, 32'h1234_5678, 6'd20, 4'd5, 1'b0, "R6 chain passthrough");
    step(32'h0000_8000, 1'b1, 32'h1111_0000, 6'd50, 4'd6, 1'b0, "R6 chain higher");
    step(32'h0000_8000, 1'b1, 32'h2222_0000, 6'd49, 4'd6, 1'b0, "R6 chain equal");
    step(32'h0000_8000, 1'b1, 32'h3333_0000, 6'd48, 4'd6, 1'b0, "R6 chain lower");
    step(32'h4000_0000, 1'b1, 32'h4444_0000, 6'd0, 4'd7, 1'b1, "R6 chain nmi equal");
    step(32'h4000_0000, 1'b1, 32'h5555_0000, 6'd5, 4'd7, 1'b1, "R6 chain nmi higher");
    step('0, 1'b0, '0, '0, '0, 1'b0, "R7 R8 final idle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule